// File: doc/BRIEF.md
# UART receiver with sticky framing-error flag

This block is the receive half of a small-controller serial port. It watches the serial line at sixteen samples per bit, confirms start bits, and decides each bit by a majority vote. It assembles frames of eight data bits, or of nine data bits where the ninth lands in its own status field. A single control/status byte holds the frame-format selection, the receive enable, the received ninth bit, a receive-complete flag and a framing-error flag. The receive buffer is a separate output.

Framing-error detection is switched on by a dedicated input. When it is on, the stop bit of every frame is judged. A stop bit sampled low sets the error flag, which then stays set until software writes it to 0. Detection also moves the moment the receive-complete flag rises, from the vote of the last data bit to the vote of the stop bit. The error flag has no bit of its own. It shares the top bit of the control byte with the upper format-select bit, and the detection input decides which of the two that bit reads and writes. The hidden format bit keeps its value and goes on selecting the frame format.

Software clears the receive-complete flag by writing 0 to it, and a frame is only taken while that flag is clear. A frame that ends while the flag is still set is dropped completely.

Top module: `uart_rx_fe`

## Requirements
- R1: After reset the control byte reads 0x00 and the receive buffer reads 0x00.
- R2: A frame starts when a high-to-low transition is seen on a sample tick. The start is confirmed by the majority of samples 7, 8 and 9, counted from that tick as sample 0. A majority of 1 is a false start: the receiver goes back to idle and no flag or buffer changes.
- R3: Each data bit is the majority of its samples 7, 8 and 9, shifted in LSB first. With format bits [7:6] = 01, a frame carries 8 data bits, the buffer takes them, and bit 2 reads 0.
- R4: With format bits [7:6] = 10 or 11, a frame carries 9 data bits. Bits 0..7 go to the buffer and the ninth bit goes to control bit 2.
- R5: No frame is received while the receive-enable bit (bit 4) is 0, or while the format bits are 00.
- R6: With detection on, receive-complete (bit 0) rises at the vote of the stop bit. With detection off, it rises at the vote of the last data bit, before the stop bit begins.
- R7: With detection on, a stop bit voted 0 sets the framing-error flag. The flag then survives later good frames and writes of 1, and only a write of 0 to bit 7 while detection is on, or a reset, clears it. With detection off, no frame sets it.
- R8: Bit 7 reads and writes the framing-error flag when detection is on, and the upper format bit when it is off. The format bit keeps its value and its effect while hidden.
- R9: A frame that completes while receive-complete is 1 is discarded. The buffer, bit 2 and the framing-error flag stay unchanged.
- R10: Receive-complete is cleared only by writing 0 to bit 0. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick16 | input | 1 | One-cycle enable, sixteen per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| fe_detect_en | input | 1 | Selects framing-error detection and the meaning of control bit 7 |
| csr_wr | input | 1 | Write strobe for the control byte |
| csr_wdata | input | 8 | Write data: [7] format-hi or error flag, [6] format-lo, [4] receive enable, [0] receive-complete |
| csr_rdata | output | 8 | Control byte: [7] format-hi or error flag, [6] format-lo, [4] receive enable, [2] ninth bit, [0] receive-complete; others 0 |
| rx_buf | output | 8 | Last accepted data byte |

## Verification
A wrong bit counter or sample point shows up at the ports as a wrong buffer value. It also moves the rise of receive-complete by at least one tick, and the per-cycle comparison with the bench's reference model catches that in the very cycle the flag moves. A lost or spurious error flag appears on bit 7 as soon as detection is on. A wrongly updated hidden format bit appears when detection is switched off, or in the next frame's length, shown through bit 2 and the buffer. A discard or stickiness fault appears on the first frame or write that should leave the state alone.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CSR_W = 8;
  localparam int BIT_FMT_HI = 7;
  localparam int BIT_FMT_LO = 6;
  localparam int BIT_RX_EN = 4;
  localparam int BIT_NINTH = 2;
  localparam int BIT_DONE = 0;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_line_sampler.sv
module rx_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic line_o,
  output logic fall_o,
  output logic vote_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [1:0]             hist_q, hist_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], rxd};
    line_o = sync_q[SYNC_STAGES-1];
    hist_d = tick ? {hist_q[0], line_o} : hist_q;
    fall_o = tick & hist_q[0] & ~line_o;
    vote_o = (line_o & hist_q[0]) | (line_o & hist_q[1]) | (hist_q[0] & hist_q[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fall,
  input  logic              vote,
  input  logic [1:0]        mode,
  input  logic              rx_en,
  input  logic              fe_en,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              bad_stop_o
);
  localparam int CNT_W   = $clog2(OVS);
  localparam int VOTE_AT = OVS / 2 + 1;
  localparam int FRAME_W = DATA_W + 1;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  rx_state_t          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] sh_q, sh_d, frame_w;
  logic               nine_q, nine_d;
  logic [IDX_W-1:0]   last_idx;
  logic               at_vote, at_end;

  always_comb begin
    last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    at_vote  = tick && (cnt_q == CNT_W'(VOTE_AT));
    at_end   = tick && (cnt_q == CNT_W'(OVS - 1));
    frame_w  = sh_q;
    if (state_q == RX_DATA && at_vote) frame_w[idx_q] = vote;

    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    nine_d     = nine_q;
    load_o     = 1'b0;
    bad_stop_o = 1'b0;

    case (state_q)
      RX_IDLE: begin
        if (tick && fall && rx_en && (mode != 2'b00)) begin
          state_d = RX_START;
          cnt_d   = CNT_W'(1);
          idx_d   = '0;
          sh_d    = '0;
          nine_d  = mode[1];
        end
      end
      RX_START: begin
        if (tick) cnt_d = cnt_q + 1'b1;
        if (at_vote && vote) begin
          state_d = RX_IDLE;
        end else if (at_end) begin
          state_d = RX_DATA;
          idx_d   = '0;
        end
      end
      RX_DATA: begin
        if (tick) cnt_d = cnt_q + 1'b1;
        if (at_vote) begin
          sh_d = frame_w;
          if (idx_q == last_idx && !fe_en) load_o = 1'b1;
        end
        if (at_end) begin
          if (idx_q == last_idx) state_d = RX_STOP;
          else idx_d = idx_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (tick) cnt_d = cnt_q + 1'b1;
        if (at_vote) begin
          state_d = RX_IDLE;
          if (fe_en) begin
            load_o     = 1'b1;
            bad_stop_o = ~vote;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase

    data_o = frame_w[DATA_W-1:0];
    bit9_o = nine_q & frame_w[DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      nine_q  <= nine_d;
    end
  end

  // R6: completion point follows the detection setting
  a_r6_fe_load_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && fe_en) |-> (state_q == RX_STOP));
  a_r6_nofe_load_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && !fe_en) |-> (state_q == RX_DATA));
  // R5: disabled receiver never leaves idle
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !rx_en) |=> (state_q == RX_IDLE));
  // R2: a false start returns to idle
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && at_vote && vote) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rx_ctrl_reg.sv
module rx_ctrl_reg
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CSR_W-1:0]  wdata,
  input  logic              fe_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_b9,
  input  logic              bad_stop,
  output logic [CSR_W-1:0]  rdata,
  output logic [DATA_W-1:0] rbuf,
  output logic [1:0]        mode_o,
  output logic              rx_en_o
);
  logic              fmt_hi_q, fmt_hi_d;
  logic              fmt_lo_q, fmt_lo_d;
  logic              rx_en_q, rx_en_d;
  logic              b9_q, b9_d;
  logic              done_q, done_d;
  logic              ferr_q, ferr_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              accept;

  always_comb begin
    accept   = load & ~done_q;
    fmt_hi_d = fmt_hi_q;
    fmt_lo_d = fmt_lo_q;
    rx_en_d  = rx_en_q;
    b9_d     = b9_q;
    rbuf_d   = rbuf_q;
    done_d   = done_q;
    ferr_d   = ferr_q;

    if (wr) begin
      if (!fe_en) fmt_hi_d = wdata[BIT_FMT_HI];
      else if (!wdata[BIT_FMT_HI]) ferr_d = 1'b0;
      fmt_lo_d = wdata[BIT_FMT_LO];
      rx_en_d  = wdata[BIT_RX_EN];
      if (!wdata[BIT_DONE]) done_d = 1'b0;
    end
    if (accept) begin
      rbuf_d = load_data;
      b9_d   = load_b9;
      done_d = 1'b1;
      if (bad_stop) ferr_d = 1'b1;
    end

    rdata             = '0;
    rdata[BIT_FMT_HI] = fe_en ? ferr_q : fmt_hi_q;
    rdata[BIT_FMT_LO] = fmt_lo_q;
    rdata[BIT_RX_EN]  = rx_en_q;
    rdata[BIT_NINTH]  = b9_q;
    rdata[BIT_DONE]   = done_q;
    rbuf              = rbuf_q;
    mode_o            = {fmt_hi_q, fmt_lo_q};
    rx_en_o           = rx_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_hi_q <= 1'b0;
      fmt_lo_q <= 1'b0;
      rx_en_q  <= 1'b0;
      b9_q     <= 1'b0;
      done_q   <= 1'b0;
      ferr_q   <= 1'b0;
      rbuf_q   <= '0;
    end else begin
      fmt_hi_q <= fmt_hi_d;
      fmt_lo_q <= fmt_lo_d;
      rx_en_q  <= rx_en_d;
      b9_q     <= b9_d;
      done_q   <= done_d;
      ferr_q   <= ferr_d;
      rbuf_q   <= rbuf_d;
    end
  end

  // R7: error flag sticky unless a clearing write arrives
  a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q && !(wr && fe_en && !wdata[BIT_FMT_HI])) |=> ferr_q);
  a_r7_no_fe_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_en && !ferr_q) |=> !ferr_q);
  // R10: receive-complete sticky unless written 0
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr && !wdata[BIT_DONE])) |=> done_q);
  // R9: frames completing over a set flag are dropped
  a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (load && done_q) |=> ($stable(rbuf_q) && $stable(b9_q)));
  // R8: hidden format bit untouched while detection is on
  a_r8_hidden_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    fe_en |=> $stable(fmt_hi_q));
endmodule

// File: rtl/uart_rx_fe.sv
module uart_rx_fe
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick16,
  input  logic              rxd,
  input  logic              fe_detect_en,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic [DATA_W-1:0] rx_buf
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              line, fall, vote;
  logic [1:0]        mode;
  logic              rx_en;
  logic              load, b9, bad_stop;
  logic [DATA_W-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rx_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_int_n), .tick(baud_tick16), .rxd(rxd),
    .line_o(line), .fall_o(fall), .vote_o(vote)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .tick(baud_tick16), .fall(fall), .vote(vote),
    .mode(mode), .rx_en(rx_en), .fe_en(fe_detect_en),
    .load_o(load), .data_o(data), .bit9_o(b9), .bad_stop_o(bad_stop)
  );

  rx_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr(csr_wr), .wdata(csr_wdata),
    .fe_en(fe_detect_en), .load(load), .load_data(data), .load_b9(b9),
    .bad_stop(bad_stop), .rdata(csr_rdata), .rbuf(rx_buf),
    .mode_o(mode), .rx_en_o(rx_en)
  );

  logic unused_line;
  assign unused_line = line;
endmodule

// File: tb/test_uart_rx_fe.sv
module test_uart_rx_fe;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       fe_en = 1'b0;
  logic       csr_wr = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic [7:0] csr_rdata;
  logic [7:0] rx_buf;

  int compared = 0;
  int mismatched = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  uart_rx_fe i_uart_rx_fe (
    .clk(clk), .rst_n(rst_n), .baud_tick16(tick), .rxd(rxd),
    .fe_detect_en(fe_en), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .rx_buf(rx_buf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % TICK_DIV;
    tick <= (tick_cnt == 0);
  end

  // reference model, behavioural
  int m_rc, m_st, m_cnt, m_idx, m_last;
  bit m_s1, m_s2, m_h0, m_h1, m_line, m_fall, m_vote, m_ld, m_bad, m_acc;
  bit m_fhi, m_flo, m_ren, m_b9, m_done, m_fe, m_nine;
  bit [8:0] m_sh;
  bit [7:0] m_buf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rc = 0; m_s1 = 1; m_s2 = 1; m_h0 = 1; m_h1 = 1;
      m_st = 0; m_cnt = 0; m_idx = 0; m_sh = 0; m_nine = 0;
      m_fhi = 0; m_flo = 0; m_ren = 0; m_b9 = 0; m_done = 0; m_fe = 0; m_buf = 0;
    end else begin
      m_rc++;
      if (m_rc >= 3) begin
        m_line = m_s2;
        m_fall = tick && m_h0 && !m_line;
        m_vote = (m_line + m_h0 + m_h1) >= 2;
        m_ld = 0; m_bad = 0;
        m_last = m_nine ? 8 : 7;
        case (m_st)
          0: if (tick && m_fall && m_ren && {m_fhi, m_flo} != 2'b00) begin
               m_st = 1; m_cnt = 1; m_nine = m_fhi; m_sh = 0; m_idx = 0;
             end
          1: if (tick) begin
               if (m_cnt == 9 && m_vote) m_st = 0;
               else if (m_cnt == 15) begin m_st = 2; m_idx = 0; end
               m_cnt = (m_cnt + 1) % 16;
             end
          2: if (tick) begin
               if (m_cnt == 9) begin
                 m_sh[m_idx] = m_vote;
                 if (m_idx == m_last && !fe_en) m_ld = 1;
               end
               if (m_cnt == 15) begin
                 if (m_idx == m_last) m_st = 3; else m_idx++;
               end
               m_cnt = (m_cnt + 1) % 16;
             end
          default: if (tick) begin
               if (m_cnt == 9) begin
                 m_st = 0;
                 if (fe_en) begin m_ld = 1; m_bad = !m_vote; end
               end
               m_cnt = (m_cnt + 1) % 16;
             end
        endcase
        m_acc = m_ld && !m_done;
        if (csr_wr) begin
          if (!fe_en) m_fhi = csr_wdata[7];
          else if (!csr_wdata[7]) m_fe = 0;
          m_flo = csr_wdata[6];
          m_ren = csr_wdata[4];
          if (!csr_wdata[0]) m_done = 0;
        end
        if (m_acc) begin
          m_buf = m_sh[7:0];
          m_b9 = m_nine & m_sh[8];
          m_done = 1;
          if (m_bad) m_fe = 1;
        end
        if (tick) begin m_h1 = m_h0; m_h0 = m_line; end
        m_s2 = m_s1; m_s1 = rxd;
      end
    end
  end

  function automatic string bit_tag(input logic [7:0] diff);
    if (diff[0]) return "R10";
    if (diff[2]) return "R4";
    if (diff[7]) return "R8";
    if (diff[4] || diff[6]) return "R5";
    return "R3";
  endfunction

  always @(negedge clk) begin
    logic [7:0] exp_r;
    if (cmp_on) begin
      exp_r = {fe_en ? m_fe : m_fhi, m_flo, 1'b0, m_ren, 1'b0, m_b9, 1'b0, m_done};
      compared++;
      if (csr_rdata !== exp_r) begin
        mismatched++;
        $display("FAIL %s per-cycle csr actual=%02h expected=%02h t=%0t",
                 bit_tag(csr_rdata ^ exp_r), csr_rdata, exp_r, $time);
      end
      compared++;
      if (rx_buf !== m_buf) begin
        mismatched++;
        $display("FAIL R3 per-cycle buffer actual=%02h expected=%02h t=%0t", rx_buf, m_buf, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    compared++;
    if (act != exp_v) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic wr_csr(input logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input bit v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nbits, input bit stop_v,
                            input int done_at_stop);
    send_bit(1'b0);
    for (int i = 0; i < nbits; i++) send_bit(d[i]);
    chk("R6 done before stop", int'(csr_rdata[0]), done_at_stop);
    send_bit(stop_v);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    chk("R1 reset csr", int'(csr_rdata), 8'h00);
    chk("R1 reset buffer", int'(rx_buf), 8'h00);

    // 8-bit format, detection off
    wr_csr(8'h50);
    send_frame(9'h0A5, 8, 1'b1, 1);
    chk("R3 buffer", int'(rx_buf), 8'hA5);
    chk("R3 done", int'(csr_rdata[0]), 1);
    chk("R3 ninth reads 0", int'(csr_rdata[2]), 0);
    send_frame(9'h03C, 8, 1'b1, 1);
    chk("R9 discarded byte", int'(rx_buf), 8'hA5);
    wr_csr(8'h51);
    chk("R10 write 1 keeps done", int'(csr_rdata[0]), 1);
    wr_csr(8'h50);
    chk("R10 write 0 clears", int'(csr_rdata[0]), 0);
    wr_csr(8'h51);
    chk("R10 write 1 no set", int'(csr_rdata[0]), 0);

    send_frame(9'h081, 8, 1'b0, 1);
    chk("R3 bad stop byte kept", int'(rx_buf), 8'h81);
    chk("R7 no flag when off", int'(csr_rdata[7]), 0);
    fe_en = 1'b1;
    @(negedge clk);
    chk("R7 flag clear after off frame", int'(csr_rdata[7]), 0);
    wr_csr(8'h50);

    // detection on
    send_frame(9'h05A, 8, 1'b1, 0);
    chk("R6 done at stop", int'(csr_rdata[0]), 1);
    chk("R7 good stop no flag", int'(csr_rdata[7]), 0);
    send_frame(9'h077, 8, 1'b0, 1);
    chk("R9 dropped keeps flag", int'(csr_rdata[7]), 0);
    chk("R9 dropped keeps buffer", int'(rx_buf), 8'h5A);
    wr_csr(8'h50);
    send_frame(9'h00F, 8, 1'b0, 0);
    chk("R7 bad stop sets flag", int'(csr_rdata[7]), 1);
    chk("R7 bad stop buffer", int'(rx_buf), 8'h0F);
    wr_csr(8'hD0);
    chk("R7 write 1 ignored", int'(csr_rdata[7]), 1);
    chk("R10 cleared", int'(csr_rdata[0]), 0);
    send_frame(9'h011, 8, 1'b1, 0);
    chk("R7 sticky past good frame", int'(csr_rdata[7]), 1);
    chk("R3 buffer", int'(rx_buf), 8'h11);
    wr_csr(8'h50);
    chk("R7 write 0 clears", int'(csr_rdata[7]), 0);

    // aliasing
    fe_en = 1'b0;
    @(negedge clk);
    chk("R8 hidden format kept", int'(csr_rdata), 8'h50);
    wr_csr(8'h90);
    chk("R8 format write", int'(csr_rdata), 8'h90);
    fe_en = 1'b1;
    @(negedge clk);
    chk("R8 bit7 shows flag", int'(csr_rdata), 8'h10);
    send_frame(9'h133, 9, 1'b1, 0);
    chk("R4 buffer", int'(rx_buf), 8'h33);
    chk("R4 ninth bit", int'(csr_rdata[2]), 1);

    fe_en = 1'b0;
    @(negedge clk);
    wr_csr(8'hD0);
    chk("R8 format 11", int'(csr_rdata[7:6]), 3);
    send_frame(9'h0C6, 9, 1'b0, 1);
    chk("R4 buffer", int'(rx_buf), 8'hC6);
    chk("R4 ninth 0", int'(csr_rdata[2]), 0);
    chk("R7 off no flag", int'(csr_rdata[7]), 1);
    fe_en = 1'b1;
    @(negedge clk);
    chk("R7 off frame left flag clear", int'(csr_rdata[7]), 0);
    wr_csr(8'h50);
    send_frame(9'h1E5, 9, 1'b0, 0);
    chk("R7 9-bit bad stop", int'(csr_rdata), 8'hD5);
    chk("R4 buffer", int'(rx_buf), 8'hE5);
    wr_csr(8'h50);
    fe_en = 1'b0;
    @(negedge clk);
    chk("R8 hidden format 1", int'(csr_rdata), 8'hD4);

    // receive disabled / format 00
    wr_csr(8'hC0);
    send_frame(9'h055, 8, 1'b1, 0);
    chk("R5 rx disabled", int'(csr_rdata[0]), 0);
    chk("R5 buffer unchanged", int'(rx_buf), 8'hE5);
    wr_csr(8'h10);
    send_frame(9'h055, 8, 1'b1, 0);
    chk("R5 format 00", int'(csr_rdata[0]), 0);
    chk("R5 buffer unchanged", int'(rx_buf), 8'hE5);

    // false start
    wr_csr(8'h50);
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    send_bit(1'b1);
    send_bit(1'b1);
    chk("R2 false start no flag", int'(csr_rdata[0]), 0);
    chk("R2 false start buffer", int'(rx_buf), 8'hE5);
    send_frame(9'h096, 8, 1'b1, 1);
    chk("R2 next frame ok", int'(rx_buf), 8'h96);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule